// File: doc/BRIEF.md
# Set-Associative Translation Cache Front-End

This block sits between a requester and a page-table walk path and remembers recent translations from virtual page number to physical page number. A request carries a virtual address made of a page number and a page offset. The low bits of the page number select one set, and the remaining bits form the tag. The tag is compared against every way of that set at once. On a match, the physical address and the stored permission bits come back in the same cycle, and nothing is sent to memory.

On a mismatch, the block holds the request. It raises a single entry fetch on its walk port and waits for the reply. A valid reply is written into the set, into the way chosen by that set's rotating pointer, and the same reply completes the request. A reply marked invalid is passed straight to the requester as a fault and is not stored.

A flush input clears every stored translation. It is meant for switches between address spaces.

Top module: `tlb_front`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `resp_valid` and `walk_req_valid` are 0, and no translation is stored, so the first request of any page misses.
- R2: A request accepted while `req_ready` is 1 that matches a stored entry gives `resp_valid`=1 and `resp_hit`=1 in the same cycle. It returns the stored page number and permission bits and raises no walk request.
- R3: `req_va` is `{vpn, offset}`. The set index is `vpn[1:0]` and the tag is `vpn[7:2]`. A hit needs both the set and the tag to match.
- R4: A request that misses gives no response in its own cycle. From the next cycle until the walk reply, `walk_req_valid` is 1, `walk_vpn` holds the missing page number, and `req_ready` is 0. Exactly one walk is issued per miss, and `req_ready` returns to 1 on the cycle after the reply.
- R5: A walk reply with `walk_pte_valid`=1 gives `resp_valid`=1, `resp_hit`=0 and `resp_fault`=0 in the same cycle. It returns `{walk_ppn, offset}` and `walk_perm`, and it installs the entry so that a later request of that page hits.
- R6: A walk reply with `walk_pte_valid`=0 gives `resp_valid`=1 with `resp_fault`=1 and stores nothing, so a repeat request of that page misses again.
- R7: Each set has a rotating pointer over its 4 ways that advances by one on every install. When a fifth distinct page is installed in a full set, the oldest entry is evicted and the other three still hit.
- R8: One cycle of `flush` invalidates every stored entry. Requests made afterwards miss. A flush raised in the same cycle as a walk reply wins, and the reply is not installed.
- R9: The low 6 bits of `resp_pa` always equal the offset of the request being answered, both on a hit and after a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all stored entries |
| req_valid | input | 1 | Translation request present |
| req_va | input | 14 | Virtual address {vpn, offset} |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Response came from a stored entry |
| resp_fault | output | 1 | Walk reported the entry invalid |
| resp_pa | output | 12 | Physical address {ppn, offset} |
| resp_perm | output | 3 | Permission bits of the translation |
| walk_req_valid | output | 1 | Entry fetch pending |
| walk_vpn | output | 8 | Page number being fetched |
| walk_resp_valid | input | 1 | Walk reply present |
| walk_pte_valid | input | 1 | Fetched entry is valid |
| walk_ppn | input | 6 | Fetched physical page number |
| walk_perm | input | 3 | Fetched permission bits |

## Verification
The assertions assume that `walk_resp_valid` is raised only while a walk is pending. They also assume the requester offers nothing new until `req_ready` returns. The stimulus keeps to this by pulsing the reply only after it has seen `walk_req_valid` and by driving one request at a time. The walk port is fed from a page table the bench computes arithmetically. Every fifth page number is marked invalid, and the reply delay varies from zero to two cycles. A 600-request sweep in scrambled order, together with directed eviction and flush sequences, covers all sets and tags.

// File: rtl/tlb_front.sv
module tlb_front #(
  parameter int VPN_W  = 8,
  parameter int IDX_W  = 2,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 6,
  parameter int PPN_W  = 6,
  parameter int PERM_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic [VPN_W+OFF_W-1:0]   req_va,
  output logic                     req_ready,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic                     resp_fault,
  output logic [PPN_W+OFF_W-1:0]   resp_pa,
  output logic [PERM_W-1:0]        resp_perm,
  output logic                     walk_req_valid,
  output logic [VPN_W-1:0]         walk_vpn,
  input  logic                     walk_resp_valid,
  input  logic                     walk_pte_valid,
  input  logic [PPN_W-1:0]         walk_ppn,
  input  logic [PERM_W-1:0]        walk_perm
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic                        busy_q;
  logic [VPN_W-1:0]            vpn_q;
  logic [OFF_W-1:0]            off_q;
  logic [SETS-1:0][WAYS-1:0]   valid_q;
  logic [SETS-1:0][WAY_W-1:0]  rr_q;
  logic [TAG_W-1:0]            tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]            ppn_q  [SETS][WAYS];
  logic [PERM_W-1:0]           perm_q [SETS][WAYS];

  logic [VPN_W-1:0]  req_vpn;
  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  fill_idx;
  logic              hit, lookup, fill;
  logic [PPN_W-1:0]  hit_ppn;
  logic [PERM_W-1:0] hit_perm;

  assign req_vpn  = req_va[VPN_W+OFF_W-1:OFF_W];
  assign req_off  = req_va[OFF_W-1:0];
  assign req_idx  = req_vpn[IDX_W-1:0];
  assign req_tag  = req_vpn[VPN_W-1:IDX_W];
  assign fill_idx = vpn_q[IDX_W-1:0];

  always_comb begin
    hit      = 1'b0;
    hit_ppn  = '0;
    hit_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[req_idx][w] && tag_q[req_idx][w] == req_tag) begin
        hit      = 1'b1;
        hit_ppn  = ppn_q[req_idx][w];
        hit_perm = perm_q[req_idx][w];
      end
    end
  end

  assign lookup         = req_valid && !busy_q;
  assign fill           = busy_q && walk_resp_valid && walk_pte_valid && !flush;
  assign req_ready      = !busy_q;
  assign resp_hit       = lookup && hit;
  assign resp_valid     = resp_hit || (busy_q && walk_resp_valid);
  assign resp_fault     = busy_q && walk_resp_valid && !walk_pte_valid;
  assign resp_pa        = busy_q ? {walk_ppn, off_q} : {hit_ppn, req_off};
  assign resp_perm      = busy_q ? walk_perm : hit_perm;
  assign walk_req_valid = busy_q;
  assign walk_vpn       = vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vpn_q  <= '0;
      off_q  <= '0;
    end else if (busy_q) begin
      if (walk_resp_valid) busy_q <= 1'b0;
    end else if (lookup && !hit) begin
      busy_q <= 1'b1;
      vpn_q  <= req_vpn;
      off_q  <= req_off;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else if (fill) begin
      valid_q[fill_idx][rr_q[fill_idx]] <= 1'b1;
      rr_q[fill_idx] <= rr_q[fill_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[fill_idx][rr_q[fill_idx]]  <= vpn_q[VPN_W-1:IDX_W];
      ppn_q[fill_idx][rr_q[fill_idx]]  <= walk_ppn;
      perm_q[fill_idx][rr_q[fill_idx]] <= walk_perm;
    end
  end

  // R4
  miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !resp_hit) |=>
      (walk_req_valid && walk_vpn == $past(req_va[VPN_W+OFF_W-1:OFF_W])));

  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_resp_valid) |=> (walk_req_valid && $stable(walk_vpn)));

  // R5
  fill_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> valid_q[$past(fill_idx)][$past(rr_q[fill_idx])]);

  // R6
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_fault && !flush) |=> $stable(valid_q));

  // R7
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> rr_q[$past(fill_idx)] == WAY_W'($past(rr_q[fill_idx]) + 1'b1));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

endmodule

// File: tb/tlb_front_tb.sv
module tlb_front_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_va = '0;
  logic        req_ready, resp_valid, resp_hit, resp_fault;
  logic [11:0] resp_pa;
  logic [2:0]  resp_perm;
  logic        walk_req_valid;
  logic [7:0]  walk_vpn;
  logic        walk_resp_valid = 1'b0;
  logic        walk_pte_valid = 1'b0;
  logic [5:0]  walk_ppn = '0;
  logic [2:0]  walk_perm = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit       m_valid [4][4];
  bit [5:0] m_tag   [4][4];
  int       m_rr    [4];

  always #(CLK_P/2) clk = ~clk;

  tlb_front dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_pa(resp_pa), .resp_perm(resp_perm),
    .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn),
    .walk_resp_valid(walk_resp_valid), .walk_pte_valid(walk_pte_valid),
    .walk_ppn(walk_ppn), .walk_perm(walk_perm)
  );

  function automatic bit pt_ok(input bit [7:0] v);
    return (v % 5) != 0;
  endfunction
  function automatic bit [5:0] pt_ppn(input bit [7:0] v);
    return 6'((v * 7 + 3) % 64);
  endfunction
  function automatic bit [2:0] pt_perm(input bit [7:0] v);
    return v[2:0] ^ 3'b011;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) m_valid[s][w] = 1'b0;
  endtask

  function automatic bit model_hit(input bit [7:0] v);
    for (int w = 0; w < 4; w++)
      if (m_valid[v[1:0]][w] && m_tag[v[1:0]][w] == v[7:2]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic access(input bit [7:0] v, input bit [5:0] off, input int dly, input string lbl);
    bit exp_hit;
    exp_hit = model_hit(v);
    @(negedge clk);
    req_valid = 1'b1;
    req_va = {v, off};
    #1;
    if (exp_hit) begin
      chk(resp_valid && resp_hit, {"R2 R3 hit ", lbl}, {resp_valid, resp_hit}, 3);
      chk(resp_pa == {pt_ppn(v), off}, "R2 R9 hit pa", resp_pa, {pt_ppn(v), off});
      chk(resp_perm == pt_perm(v), "R2 hit perm", resp_perm, pt_perm(v));
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(!walk_req_valid && req_ready, "R2 no walk after hit", walk_req_valid, 0);
    end else begin
      chk(!resp_valid, {"R4 R6 R8 miss expected ", lbl}, resp_valid, 0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(walk_req_valid && walk_vpn == v && !req_ready, "R4 walk request",
          {walk_req_valid, req_ready, walk_vpn}, {2'b10, v});
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        #1;
        chk(walk_req_valid && walk_vpn == v, "R4 walk held", walk_vpn, v);
      end
      @(negedge clk);
      walk_resp_valid = 1'b1;
      walk_pte_valid = pt_ok(v);
      walk_ppn = pt_ppn(v);
      walk_perm = pt_perm(v);
      #1;
      if (pt_ok(v)) begin
        chk(resp_valid && !resp_hit && !resp_fault, "R5 walk response",
            {resp_valid, resp_hit, resp_fault}, 3'b100);
        chk(resp_pa == {pt_ppn(v), off} && resp_perm == pt_perm(v), "R5 R9 walk pa",
            resp_pa, {pt_ppn(v), off});
        m_tag[v[1:0]][m_rr[v[1:0]]] = v[7:2];
        m_valid[v[1:0]][m_rr[v[1:0]]] = 1'b1;
        m_rr[v[1:0]] = (m_rr[v[1:0]] + 1) % 4;
      end else begin
        chk(resp_valid && resp_fault, "R6 fault", {resp_valid, resp_fault}, 3);
      end
      @(negedge clk);
      walk_resp_valid = 1'b0;
      #1;
      chk(req_ready && !walk_req_valid, "R4 ready after reply", req_ready, 1);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [7:0] x;
    model_clear();
    for (int s = 0; s < 4; s++) m_rr[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready && !resp_valid && !walk_req_valid, "R1 reset outputs",
        {req_ready, resp_valid, walk_req_valid}, 3'b100);
    access(8'h11, 6'h2a, 0, "R1 first access");
    access(8'h11, 6'h05, 0, "R5 refill hit");
    access(8'h12, 6'h3f, 1, "R3 same tag other set");
    access(8'h15, 6'h00, 0, "R3 same set other tag");
    access(8'h0a, 6'h11, 2, "R6 fault page");
    access(8'h0a, 6'h12, 0, "R6 fault repeat");

    // R7 eviction in set 1
    do_flush();
    access(8'd1, 6'h01, 0, "R7 fill");
    access(8'd9, 6'h02, 1, "R7 fill");
    access(8'd13, 6'h03, 0, "R7 fill");
    access(8'd17, 6'h04, 2, "R7 fill");
    access(8'd21, 6'h05, 0, "R7 fifth");
    access(8'd9, 6'h06, 0, "R7 survivor");
    access(8'd13, 6'h07, 0, "R7 survivor");
    access(8'd17, 6'h08, 0, "R7 survivor");
    access(8'd21, 6'h09, 0, "R7 survivor");
    access(8'd1, 6'h0a, 0, "R7 evicted");

    // R8 flush then repeat
    do_flush();
    access(8'd17, 6'h0b, 0, "R8 after flush");

    // R8 flush coinciding with a walk reply
    @(negedge clk);
    req_valid = 1'b1;
    req_va = {8'd33, 6'h0c};
    @(negedge clk);
    req_valid = 1'b0;
    walk_resp_valid = 1'b1;
    walk_pte_valid = 1'b1;
    walk_ppn = pt_ppn(8'd33);
    walk_perm = pt_perm(8'd33);
    flush = 1'b1;
    @(negedge clk);
    walk_resp_valid = 1'b0;
    flush = 1'b0;
    model_clear();
    access(8'd33, 6'h0d, 0, "R8 fill dropped by flush");

    // sweep
    x = 8'h5c;
    for (int i = 0; i < 600; i++) begin
      access(x, 6'(i * 13), i % 3, "sweep");
      if (i % 4 == 3) access(x, 6'(i), 0, "sweep repeat");
      if (i == 300) do_flush();
      x = 8'(x * 37 + 11);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule